// File: doc/BRIEF.md
# Byte Data Memory with Pointer-Redirected Access

This block is the data store of a small 8-bit controller. It holds 224 bytes of general-purpose storage and two pointer registers, all of them mapped into one 8-bit address space. Two addresses in that space have no storage behind them. They act as windows: an access to either window is sent on to whatever address its pointer holds. A single read/write port serves every location. Software steps through a table by loading a pointer and then reading or writing the window that goes with it.

The address map is fixed. The first window sits at 00H and uses the pointer at 01H. The second window sits at 02H and uses the pointer at 03H. General storage spans 20H to FFH, and addresses 04H to 1FH are unmapped. A read returns data combinationally for the address on the bus in the same cycle. A write takes effect on the rising clock edge. If a pointer holds a window address, the redirected access goes nowhere: reads return zero and writes are dropped.

Top module: `dmem_indirect`

## Requirements
- R1: Addresses 20H..FFH are 224 byte cells. A write stores the byte, and a later read of the same address returns it. Every cell reads 00H after reset.
- R2: The first pointer is at address 01H and the second at 03H. Both can be written and read directly, and both read 00H after reset.
- R3: A read or write of address 00H acts on the address held by the pointer at 01H.
- R4: A read or write of address 02H acts on the address held by the pointer at 03H.
- R5: A read through a window returns 00H when its pointer holds 00H or 02H.
- R6: A write through a window changes no storage and no pointer when its pointer holds 00H or 02H.
- R7: Addresses 04H..1FH read as 00H, and writes to them change nothing.
- R8: read_data follows the address of the current cycle with no clock delay, and is 00H whenever rd_en is low. A write becomes visible only after the rising edge, so a read of the same address in the write cycle returns the old byte.
- R9: A window whose pointer holds 01H or 03H reaches that pointer register. It can read it, and a write through it reloads it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes commit on its rising edge |
| rst | input | 1 | Synchronous active-high reset; clears pointers and storage |
| addr | input | 8 | Address of the access |
| wr_data | input | 8 | Byte to write |
| wr_en | input | 1 | Write strobe for this cycle |
| rd_en | input | 1 | Read strobe; read_data is 00H when low |
| rd_data | output | 8 | Combinational read result |

## Verification
The bench builds the block with its default parameters: 8-bit addresses and data, two pointer/window pairs, and 224 storage bytes starting at 20H. Because the storage fills the top of the address space, random addresses reach the last cell FFH, the unmapped gap and all four window/pointer locations. Random traffic is biased toward the low eight addresses and toward small pointer values. This makes self-referencing pointers, pointer-to-pointer chains and window writes common, so the zero-read, dropped-write and pointer-reload cases occur many times over.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 8;
    localparam int NUM_PTR   = 2;
    localparam int RAM_BASE  = 32;
    localparam int RAM_DEPTH = 224;

    localparam int PSEL_W    = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1;
    localparam int RIDX_W    = (RAM_DEPTH > 1) ? $clog2(RAM_DEPTH) : 1;
    localparam int RAM_LAST  = RAM_BASE + RAM_DEPTH - 1;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [PSEL_W-1:0] psel_t;
    typedef logic [RIDX_W-1:0] ridx_t;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_WIN  = 2'd1,
        TGT_PTR  = 2'd2,
        TGT_RAM  = 2'd3
    } tgt_kind_e;

    typedef struct packed {
        tgt_kind_e kind;
        psel_t     sel;
        ridx_t     idx;
    } tgt_t;

    // Window k sits at even address 2k, its pointer right above it.
    function automatic addr_t win_addr(input int k);
        return addr_t'(2 * k);
    endfunction

    function automatic addr_t ptr_addr(input int k);
        return addr_t'(2 * k + 1);
    endfunction

    function automatic tgt_t classify(input addr_t a);
        tgt_t t;
        t.kind = TGT_NONE;
        t.sel  = '0;
        t.idx  = '0;
        for (int k = 0; k < NUM_PTR; k++) begin
            if (a == win_addr(k)) begin
                t.kind = TGT_WIN;
                t.sel  = psel_t'(k);
            end
            if (a == ptr_addr(k)) begin
                t.kind = TGT_PTR;
                t.sel  = psel_t'(k);
            end
        end
        if ((int'(a) >= RAM_BASE) && (int'(a) <= RAM_LAST)) begin
            t.kind = TGT_RAM;
            t.idx  = ridx_t'(int'(a) - RAM_BASE);
        end
        return t;
    endfunction

endpackage

// File: rtl/dmem_route.sv
module dmem_route
    import dmem_pkg::*;
(
    input  addr_t                      addr,
    input  logic                       wr_en,
    input  logic [NUM_PTR-1:0][DATA_W-1:0] ptr_q,
    output tgt_t                       tgt,
    output logic                       ram_we,
    output logic [NUM_PTR-1:0]         ptr_we
);

    tgt_t  first;
    addr_t eff;

    always_comb begin
        first = classify(addr);
        eff   = addr;
        for (int k = 0; k < NUM_PTR; k++) begin
            if (first.kind == TGT_WIN && first.sel == psel_t'(k))
                eff = addr_t'(ptr_q[k]);
        end
        tgt = classify(eff);
        // A window only survives a second decode when a pointer names one.
        if (tgt.kind == TGT_WIN)
            tgt.kind = TGT_NONE;
    end

    assign ram_we = wr_en && (tgt.kind == TGT_RAM);

    for (genvar k = 0; k < NUM_PTR; k++) begin : g_pwe
        assign ptr_we[k] = wr_en && (tgt.kind == TGT_PTR) && (tgt.sel == psel_t'(k));
    end

endmodule

// File: rtl/dmem_ptr_bank.sv
module dmem_ptr_bank
    import dmem_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NUM_PTR-1:0]             ptr_we,
    input  data_t                          wr_data,
    output logic [NUM_PTR-1:0][DATA_W-1:0] ptr_q
);

    for (genvar k = 0; k < NUM_PTR; k++) begin : g_ptr
        always_ff @(posedge clk) begin
            if (rst)
                ptr_q[k] <= '0;
            else if (ptr_we[k])
                ptr_q[k] <= wr_data;
        end

        a_r2_ptr_load: assert property (@(posedge clk) disable iff (rst)
            ptr_we[k] |=> ptr_q[k] == $past(wr_data));

        a_r6_ptr_hold: assert property (@(posedge clk) disable iff (rst)
            !ptr_we[k] |=> $stable(ptr_q[k]));
    end

endmodule

// File: rtl/dmem_ram.sv
module dmem_ram
    import dmem_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  ridx_t idx,
    input  data_t wd,
    output data_t rd
);

    data_t mem [RAM_DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < RAM_DEPTH; i++)
                mem[i] <= '0;
        end else if (we) begin
            mem[idx] <= wd;
        end
    end

    assign rd = mem[idx];

    a_r1_ram_commit: assert property (@(posedge clk) disable iff (rst)
        we |=> mem[$past(idx)] == $past(wd));

endmodule

// File: rtl/dmem_indirect.sv
module dmem_indirect
    import dmem_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                wr_en,
    input  logic                rd_en,
    output logic [DATA_W-1:0]   rd_data
);

    tgt_t                           tgt;
    logic                           ram_we;
    logic [NUM_PTR-1:0]             ptr_we;
    logic [NUM_PTR-1:0][DATA_W-1:0] ptr_q;
    data_t                          ram_rd;

    dmem_route u_route (
        .addr   (addr),
        .wr_en  (wr_en),
        .ptr_q  (ptr_q),
        .tgt    (tgt),
        .ram_we (ram_we),
        .ptr_we (ptr_we)
    );

    dmem_ptr_bank u_ptrs (
        .clk     (clk),
        .rst     (rst),
        .ptr_we  (ptr_we),
        .wr_data (wr_data),
        .ptr_q   (ptr_q)
    );

    dmem_ram u_ram (
        .clk (clk),
        .rst (rst),
        .we  (ram_we),
        .idx (tgt.idx),
        .wd  (wr_data),
        .rd  (ram_rd)
    );

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            unique case (tgt.kind)
                TGT_PTR: rd_data = ptr_q[tgt.sel];
                TGT_RAM: rd_data = ram_rd;
                default: rd_data = '0;
            endcase
        end
    end

    a_r8_rden_low_zero: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> rd_data == '0);

    a_r7_gap_read_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_en && int'(addr) >= 2 * NUM_PTR && int'(addr) < RAM_BASE) |-> rd_data == '0);

    a_r7_gap_write_inert: assert property (@(posedge clk) disable iff (rst)
        (wr_en && int'(addr) >= 2 * NUM_PTR && int'(addr) < RAM_BASE) |-> (!ram_we && ptr_we == '0));

    a_r5_selfref_read_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == 8'h00 && (ptr_q[0] == 8'h00 || ptr_q[0] == 8'h02)) |-> rd_data == '0);

    a_r6_selfref_write_inert: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 8'h02 && (ptr_q[1] == 8'h00 || ptr_q[1] == 8'h02)) |=> $stable(ptr_q));

    a_r2_direct_ptr_read: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == 8'h03) |-> rd_data == ptr_q[1]);

endmodule

// File: tb/dmem_indirect_tb.sv
module dmem_indirect_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;

    int  tests = 0;
    int  fails = 0;
    bit  done  = 1'b0;

    byte unsigned mdl [256];

    always #4 clk = ~clk;

    dmem_indirect u_dut (
        .clk     (clk),
        .rst     (rst),
        .addr    (addr),
        .wr_data (wr_data),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .rd_data (rd_data)
    );

    function automatic int target(input int a);
        if (a == 0) return mdl[1];
        if (a == 2) return mdl[3];
        return a;
    endfunction

    function automatic bit dead(input int e);
        return (e == 0) || (e == 2) || (e >= 4 && e < 32);
    endfunction

    function automatic string auto_tag(input int a, input bit re);
        int e;
        e = target(a);
        if (!re) return "R8";
        if (a == 0 || a == 2) begin
            if (e == 0 || e == 2) return "R5";
            if (e == 1 || e == 3) return "R9";
            return (a == 0) ? "R3" : "R4";
        end
        if (a == 1 || a == 3) return "R2";
        if (a >= 4 && a < 32) return "R7";
        return "R1";
    endfunction

    task automatic step(input int a, input int wd, input bit we, input bit re, input string tag);
        int    e;
        int    exp;
        string t;
        @(negedge clk);
        addr    = 8'(a);
        wr_data = 8'(wd);
        wr_en   = we;
        rd_en   = re;
        #2;
        e   = target(a);
        exp = (re && !dead(e)) ? int'(mdl[e]) : 0;
        t   = (tag == "") ? auto_tag(a, re) : tag;
        tests++;
        if (int'(rd_data) != exp) begin
            fails++;
            $display("FAIL %s addr=%02h actual=%02h expected=%02h", t, a, rd_data, exp);
        end
        @(posedge clk);
        if (we && !dead(e)) mdl[e] = 8'(wd);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mdl[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // reset state: R1 and R2
        step(8'h01, 0, 0, 1, "R2");
        step(8'h03, 0, 0, 1, "R2");
        step(8'h20, 0, 0, 1, "R1");
        step(8'hFF, 0, 0, 1, "R1");

        // R1 storage edges
        step(8'h20, 8'hA5, 1, 0, "R1");
        step(8'hFF, 8'h3C, 1, 0, "R1");
        step(8'h20, 0, 0, 1, "R1");
        step(8'hFF, 0, 0, 1, "R1");

        // R8 same-cycle write then read
        step(8'h40, 8'h11, 1, 1, "R8");
        step(8'h40, 8'h22, 1, 1, "R8");
        step(8'h40, 0, 0, 1, "R8");
        step(8'h40, 0, 0, 0, "R8");

        // R3 and R4 redirect
        step(8'h01, 8'h40, 1, 0, "R2");
        step(8'h00, 0, 0, 1, "R3");
        step(8'h00, 8'h77, 1, 0, "R3");
        step(8'h40, 0, 0, 1, "R3");
        step(8'h03, 8'hFF, 1, 0, "R2");
        step(8'h02, 0, 0, 1, "R4");
        step(8'h02, 8'h99, 1, 0, "R4");
        step(8'hFF, 0, 0, 1, "R4");

        // R7 gap
        step(8'h04, 8'hEE, 1, 1, "R7");
        step(8'h1F, 8'hEE, 1, 1, "R7");
        step(8'h1F, 0, 0, 1, "R7");

        // R5 and R6 self-referencing pointers
        step(8'h01, 8'h02, 1, 0, "R2");
        step(8'h00, 0, 0, 1, "R5");
        step(8'h00, 8'h5A, 1, 0, "R6");
        step(8'h01, 0, 0, 1, "R6");
        step(8'h03, 0, 0, 1, "R6");
        step(8'h03, 8'h00, 1, 0, "R2");
        step(8'h02, 8'h5A, 1, 1, "R5");
        step(8'h01, 0, 0, 1, "R6");
        step(8'h03, 0, 0, 1, "R6");

        // R9 pointer through window
        step(8'h01, 8'h03, 1, 0, "R2");
        step(8'h00, 0, 0, 1, "R9");
        step(8'h00, 8'h60, 1, 0, "R9");
        step(8'h03, 0, 0, 1, "R9");
        step(8'h02, 8'h6B, 1, 0, "R4");
        step(8'h60, 0, 0, 1, "R4");

        // mixed random traffic against the model
        for (int n = 0; n < 3000; n++) begin
            int a;
            int wd;
            a  = ($urandom_range(0, 9) < 4) ? int'($urandom_range(0, 7)) : int'($urandom_range(0, 255));
            wd = ((a == 1 || a == 3) && $urandom_range(0, 1) == 0) ? int'($urandom_range(0, 5))
                                                                    : int'($urandom_range(0, 255));
            step(a, wd, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) != 0), "");
        end

        // final sweep of all addresses
        for (int a = 0; a < 256; a++) step(a, 0, 0, 1, "");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule